// File: doc/BRIEF.md
# External Interrupt Trigger Detector

This block watches one asynchronous interrupt pin and turns it into a single interrupt request line for a simple CPU. The pin is first brought into the clock domain through a flop chain. It is then judged against one of three trigger rules. Edge mode latches an inactive-to-active transition into a pending flag, and the CPU acknowledge clears that flag. Pure level mode drives the request straight from the synchronised pin level. Latched level mode sets the pending flag whenever the pin is seen active, and only an explicit software clear removes it.

The configuration inputs (enable, trigger mode and active polarity) are captured in registers. A change of mode or polarity empties the pending flag and re-arms edge detection. While the CPU reports that it is in service mode, the request is masked but events are still recorded. The first cycle after service ends presents them again. A level-mode pin that is still active therefore retriggers at once.

Top module: `ext_irq_detector`

## Requirements
- R1: The pin passes through SYNC_STAGES flops, two by default. A pin change therefore appears on `irq_req` in pure level mode after the second rising clock edge. In edge or latched mode it appears after the third edge.
- R2: In edge mode (`trig_mode` = 2'b00, or 2'b11, which behaves the same), the pending flag sets only when the synchronised pin goes from inactive to active. A pin held active yields exactly one request, and a new request needs the pin to go inactive and active again.
- R3: In pure level mode (`trig_mode` = 2'b01), `irq_req` follows the synchronised active level for as long as that level lasts. `sw_clear` and `irq_ack` have no effect on it.
- R4: In latched level mode (`trig_mode` = 2'b10), the pending flag sets whenever the pin is seen active, and it stays set after the pin returns inactive until `sw_clear`. A `sw_clear` given while the pin is still active leaves the request asserted.
- R5: In edge mode, `irq_ack` clears the pending flag. In latched level mode, `irq_ack` has no effect.
- R6: While `in_service` is high, `irq_req` is low, but events are still recorded. When `in_service` falls, a recorded event appears on `irq_req` in that same cycle. This includes a level-mode pin that is still active.
- R7: When the registered enable is low, `irq_req` is low and the pending flag is kept. The flag is presented one cycle after `irq_enable` returns high.
- R8: With `active_high` = 0, the active state is a low pin and a falling transition. With `active_high` = 1, it is a high pin and a rising transition.
- R9: A change of `trig_mode` or `active_high` clears the pending flag. It also re-arms edge detection, so a pin that is already active after the change raises no edge request.
- R10: After reset, `irq_req` is low, the pending flag is clear, and the registered configuration is edge mode, active-low and disabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| pin_async | input | 1 | External interrupt pin, asynchronous |
| irq_enable | input | 1 | Global interrupt enable, registered |
| trig_mode | input | 2 | 00 edge, 01 pure level, 10 latched level, 11 edge |
| active_high | input | 1 | 0: active-low / falling; 1: active-high / rising |
| in_service | input | 1 | CPU is running a handler; masks the request |
| irq_ack | input | 1 | One-cycle pulse when the CPU dispatches the handler |
| sw_clear | input | 1 | One-cycle software clear of the pending flag |
| irq_req | output | 1 | Interrupt request to the CPU |

## Verification
The bench builds the block with the default two-stage synchroniser. The pin-to-request latency is therefore a fixed two edges for pure level mode and three edges for the flag-based modes, and the bench checks those exact cycles. With this depth every mode switch, polarity flip and service window settles within a few cycles. That lets short directed scenarios reach the corner cases: a clear while the pin is active, a retrigger on service exit, and re-arming after a configuration change.

// File: rtl/eid_pkg.sv
package eid_pkg;

  typedef enum logic [1:0] {
    TRIG_EDGE  = 2'b00,
    TRIG_LEVEL = 2'b01,
    TRIG_LATCH = 2'b10,
    TRIG_RSVD  = 2'b11
  } trig_mode_e;

  typedef struct packed {
    logic       enable;
    logic       act_high;
    trig_mode_e mode;
  } irq_cfg_t;

  localparam irq_cfg_t CFG_RESET = '{enable: 1'b0, act_high: 1'b0, mode: TRIG_EDGE};

endpackage

// File: rtl/eid_sync.sv
module eid_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);

  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain_q;
  logic [LAST:0] chain_d;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        assign chain_d[i] = d_async;
      end else begin : g_next
        assign chain_d[i] = chain_q[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= chain_d;
  end

  assign q_sync = chain_q[LAST];

endmodule

// File: rtl/eid_cfg.sv
module eid_cfg
  import eid_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable_in,
  input  logic [1:0] mode_in,
  input  logic       act_high_in,
  output irq_cfg_t   cfg_q,
  output logic       rearm
);

  irq_cfg_t   cfg_d;
  trig_mode_e mode_norm;

  // Reserved code behaves as edge mode.
  always_comb begin
    unique case (mode_in)
      2'b01:   mode_norm = TRIG_LEVEL;
      2'b10:   mode_norm = TRIG_LATCH;
      default: mode_norm = TRIG_EDGE;
    endcase
    cfg_d.enable   = enable_in;
    cfg_d.act_high = act_high_in;
    cfg_d.mode     = mode_norm;
  end

  // Mode or polarity about to change: the pending logic drops its state.
  assign rearm = (cfg_d.mode != cfg_q.mode) || (cfg_d.act_high != cfg_q.act_high);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= CFG_RESET;
    else        cfg_q <= cfg_d;
  end

  a_r10_reset_cfg: assert property (@(posedge clk)
    $rose(rst_n) |-> (cfg_q.mode == TRIG_EDGE && !cfg_q.act_high && !cfg_q.enable));

endmodule

// File: rtl/eid_pending.sv
module eid_pending
  import eid_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  irq_cfg_t cfg,
  input  logic     rearm,
  input  logic     pin_sync,
  input  logic     ack,
  input  logic     sw_clear,
  output logic     pend,
  output logic     act
);

  logic pend_q, pend_d;
  logic prev_q, prev_d;
  logic edge_evt;

  // Active level after polarity selection.
  assign act      = cfg.act_high ? pin_sync : ~pin_sync;
  assign edge_evt = act & ~prev_q;

  always_comb begin
    pend_d = pend_q;
    prev_d = act;
    if (rearm) begin
      pend_d = 1'b0;
      prev_d = 1'b1;
    end else begin
      unique case (cfg.mode)
        TRIG_LATCH: begin
          if (act)           pend_d = 1'b1;
          else if (sw_clear) pend_d = 1'b0;
        end
        TRIG_LEVEL: begin
          pend_d = 1'b0;
        end
        default: begin
          if (edge_evt)              pend_d = 1'b1;
          else if (ack || sw_clear)  pend_d = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      prev_q <= 1'b1;
    end else begin
      pend_q <= pend_d;
      prev_q <= prev_d;
    end
  end

  assign pend = pend_q;

  a_r9_rearm_clears: assert property (@(posedge clk) disable iff (!rst_n)
    rearm |=> !pend_q);

  a_r2_held_no_repeat: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.mode == TRIG_EDGE && !rearm && !pend_q && act && prev_q) |=> !pend_q);

  a_r5_ack_clears_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.mode == TRIG_EDGE && !rearm && ack && !edge_evt) |=> !pend_q);

  a_r4_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.mode == TRIG_LATCH && !rearm && pend_q && !sw_clear) |=> pend_q);

  a_r4_clear_while_active: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.mode == TRIG_LATCH && !rearm && act) |=> pend_q);

endmodule

// File: rtl/ext_irq_detector.sv
module ext_irq_detector
  import eid_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_async,
  input  logic       irq_enable,
  input  logic [1:0] trig_mode,
  input  logic       active_high,
  input  logic       in_service,
  input  logic       irq_ack,
  input  logic       sw_clear,
  output logic       irq_req
);

  irq_cfg_t cfg_q;
  logic     rearm;
  logic     pin_sync;
  logic     pend;
  logic     act;
  logic     src;

  eid_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (pin_async),
    .q_sync  (pin_sync)
  );

  eid_cfg u_cfg (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable_in   (irq_enable),
    .mode_in     (trig_mode),
    .act_high_in (active_high),
    .cfg_q       (cfg_q),
    .rearm       (rearm)
  );

  eid_pending u_pend (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg      (cfg_q),
    .rearm    (rearm),
    .pin_sync (pin_sync),
    .ack      (irq_ack),
    .sw_clear (sw_clear),
    .pend     (pend),
    .act      (act)
  );

  assign src     = (cfg_q.mode == TRIG_LEVEL) ? act : pend;
  assign irq_req = cfg_q.enable & ~in_service & src;

  a_r6_service_masks: assert property (@(posedge clk) disable iff (!rst_n)
    (in_service && pend && !rearm && cfg_q.mode == TRIG_LATCH) |=> pend);

  a_r7_enable_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_q.enable && pend && !rearm && !irq_ack && !sw_clear) |=> pend);

endmodule

// File: tb/ext_irq_detector_test.sv
`timescale 1ns/1ps
module ext_irq_detector_test;

  localparam time CLK_P = 10ns;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       pin_async;
  logic       irq_enable;
  logic [1:0] trig_mode;
  logic       active_high;
  logic       in_service;
  logic       irq_ack;
  logic       sw_clear;
  logic       irq_req;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  ext_irq_detector #(.SYNC_STAGES(2)) uut (
    .clk(clk), .rst_n(rst_n), .pin_async(pin_async), .irq_enable(irq_enable),
    .trig_mode(trig_mode), .active_high(active_high), .in_service(in_service),
    .irq_ack(irq_ack), .sw_clear(sw_clear), .irq_req(irq_req)
  );

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic exp);
    checks++;
    if (irq_req !== exp) begin
      errors++;
      $display("FAIL %s: irq_req=%b expected %b at %0t", tag, irq_req, exp, $time);
    end
  endtask

  task automatic pulse_ack();
    irq_ack = 1'b1; cyc(1); irq_ack = 1'b0;
  endtask

  task automatic pulse_clr();
    sw_clear = 1'b1; cyc(1); sw_clear = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; pin_async = 1'b1; irq_enable = 1'b0; trig_mode = 2'b00;
    active_high = 1'b0; in_service = 1'b0; irq_ack = 1'b0; sw_clear = 1'b0;
    cyc(3);
    chk("R10 in reset", 1'b0);
    rst_n = 1'b1;
    cyc(3);
    chk("R10 after reset", 1'b0);
    irq_enable = 1'b1;
    cyc(4);
    chk("R10 no pending after reset", 1'b0);
  endtask

  task automatic t_edge();
    pin_async = 1'b0;
    cyc(2); chk("R1 edge not yet after two edges", 1'b0);
    cyc(1); chk("R1 R2 edge request on third edge", 1'b1);
    cyc(4); chk("R2 held until ack", 1'b1);
    pulse_ack(); chk("R5 ack clears edge flag", 1'b0);
    cyc(5); chk("R2 held pin gives no second request", 1'b0);
    pin_async = 1'b1; cyc(4);
    pin_async = 1'b0; cyc(4);
    chk("R2 new falling edge", 1'b1);
    pulse_ack(); pin_async = 1'b1; cyc(4);
    trig_mode = 2'b11; cyc(3);
    pin_async = 1'b0; cyc(4);
    chk("R2 reserved code acts as edge", 1'b1);
    pulse_ack(); cyc(1); chk("R5 ack in reserved code", 1'b0);
    pin_async = 1'b1; cyc(4);
  endtask

  task automatic t_pure();
    trig_mode = 2'b01; cyc(3);
    chk("R3 pure idle", 1'b0);
    pin_async = 1'b0;
    cyc(1); chk("R1 pure after one edge", 1'b0);
    cyc(1); chk("R1 R3 pure after two edges", 1'b1);
    pulse_clr(); chk("R3 sw_clear no effect", 1'b1);
    pulse_ack(); chk("R3 ack no effect", 1'b1);
    pin_async = 1'b1; cyc(2);
    chk("R3 pure follows release", 1'b0);
  endtask

  task automatic t_latched();
    trig_mode = 2'b10; cyc(3);
    pin_async = 1'b0; cyc(4);
    chk("R4 latched set", 1'b1);
    pin_async = 1'b1; cyc(4);
    chk("R4 kept after release", 1'b1);
    pulse_ack(); cyc(1); chk("R5 ack ignored in latched", 1'b1);
    pulse_clr(); chk("R4 sw_clear removes", 1'b0);
    pin_async = 1'b0; cyc(4);
    pulse_clr(); cyc(1); chk("R4 clear while active ignored", 1'b1);
    pin_async = 1'b1; cyc(4);
    pulse_clr(); chk("R4 clear after release", 1'b0);
  endtask

  task automatic t_service();
    in_service = 1'b1;
    pin_async = 1'b0; cyc(4);
    chk("R6 masked in service (latched)", 1'b0);
    in_service = 1'b0; #1;
    chk("R6 presented when service ends", 1'b1);
    cyc(1);
    trig_mode = 2'b01; cyc(3);
    in_service = 1'b1; cyc(2);
    chk("R6 pure masked in service", 1'b0);
    in_service = 1'b0; #1;
    chk("R6 pure retriggers on return", 1'b1);
    cyc(1);
    pin_async = 1'b1; trig_mode = 2'b00; cyc(4);
    in_service = 1'b1; pin_async = 1'b0; cyc(4);
    chk("R6 edge masked in service", 1'b0);
    in_service = 1'b0; #1;
    chk("R6 edge presented after service", 1'b1);
    cyc(1); pulse_ack(); pin_async = 1'b1; cyc(4);
  endtask

  task automatic t_enable();
    irq_enable = 1'b0; cyc(2);
    pin_async = 1'b0; cyc(4);
    chk("R7 disabled masks", 1'b0);
    irq_enable = 1'b1; cyc(1);
    chk("R7 pending kept and shown", 1'b1);
    pulse_ack(); pin_async = 1'b1; cyc(4);
  endtask

  task automatic t_polarity();
    active_high = 1'b1; cyc(4);
    chk("R9 polarity flip no false event", 1'b0);
    pin_async = 1'b0; cyc(4);
    chk("R8 falling ignored when active-high", 1'b0);
    pin_async = 1'b1; cyc(4);
    chk("R8 rising edge request", 1'b1);
    pulse_ack(); cyc(1);
    trig_mode = 2'b01; cyc(3);
    chk("R8 high level active", 1'b1);
    trig_mode = 2'b10; cyc(3);
    pin_async = 1'b0; cyc(4);
    chk("R4 latched held active-high", 1'b1);
    trig_mode = 2'b00; cyc(3);
    chk("R9 mode change clears pending", 1'b0);
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_edge();
    t_pure();
    t_latched();
    t_service();
    t_enable();
    t_polarity();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule